// File: doc/BRIEF.md
# Page-Mode DRAM Row Controller

This block runs on a system clock and drives an asynchronous DRAM that takes its address in two halves. It uses a row strobe, a column strobe, a write enable, an output enable and one shared address bus. A host issues read and write requests over a valid/ready port. The controller opens the requested row by presenting the row address and lowering the row strobe. Each access is then served as a column cycle: the column address is presented and the column strobe pulses low. While the row stays open, a following request to the same row is served as another column cycle alone, without reissuing the row.

The row is closed by raising the row strobe in four cases: the next request targets a different row, the host has nothing pending, a refresh scheduler asks for the bus, or the row has been open so long that one more column cycle would exceed the maximum row-active time. Writes come in two forms, chosen per request. In the early form, write enable falls before the column strobe. In the late form, write enable falls after the column strobe, and output enable is raised before the controller turns on its data drivers. Read data is sampled a fixed number of cycles after the column strobe falls and is returned with a one-cycle valid pulse. Refresh is handed over through a request/grant pair. While the grant is up, the controller keeps every strobe high and starts no new row.

Top module: `pgdram_ctrl`

## Requirements
- R1: After reset all four strobes are high (inactive), the data drivers are off, `rsp_valid` and `ref_gnt` are low, and no row counts as open, so the first accepted request starts with a fall of `dram_ras_n`.
- R2: The row address is on `dram_addr` and stays unchanged across the clock edge where `dram_ras_n` falls. The column address likewise stays unchanged across each fall of `dram_cas_n`. `dram_cas_n` is low only while `dram_ras_n` is low.
- R3: A request accepted while its row is open, arriving on the cycle after the previous column cycle finishes, is served with another `dram_cas_n` pulse and no new `dram_ras_n` fall.
- R4: A request to a row other than the open one first makes `dram_ras_n` rise, then opens the new row with a fresh `dram_ras_n` fall.
- R5: Between a rise of `dram_ras_n` and its next fall there are at least T_RP cycles.
- R6: The first `dram_cas_n` fall after a `dram_ras_n` fall comes exactly T_RCD+1 cycles after it.
- R7: `dram_cas_n` stays low for exactly T_CAS cycles per access and stays high for at least T_CP cycles between two accesses in one row.
- R8: An early write (`req_we`=1, `req_late`=0) has `dram_we_n` low and `dram_dq_oe` high already when `dram_cas_n` falls, and the DRAM stores `req_wdata`.
- R9: A late write (`req_we`=1, `req_late`=1) keeps `dram_we_n` high at the `dram_cas_n` fall and drops it one cycle later. `dram_dq_oe` is never high unless `dram_oe_n` is high.
- R10: For a read, the data on `dram_dq_in` is sampled RD_LAT cycles after `dram_cas_n` falls. It appears on `rsp_rdata` with a one-cycle `rsp_valid` pulse, and each read yields exactly one pulse.
- R11: `dram_ras_n` never stays low for more than T_RASMAX cycles. With the default parameters, twelve back-to-back same-row requests use exactly two row openings.
- R12: `ref_gnt` rises only after `ref_req` has been high. While it is high, `dram_ras_n` and `dram_cas_n` are high and no row is opened. A `ref_req` that arrives while a row is open closes that row.
- R13: When `req_valid` is low at the end of a column cycle, the row is closed, and `dram_ras_n` is high a few cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_late | input | 1 | For writes: 1 = late write, 0 = early write |
| req_row | input | ROW_W | Row address |
| req_col | input | COL_W | Column address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | DATA_W | Read data |
| ref_req | input | 1 | Refresh scheduler wants the bus |
| ref_gnt | output | 1 | Bus handed to refresh |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed address |
| dram_dq_out | output | DATA_W | Data driven to the DRAM |
| dram_dq_oe | output | 1 | Enables the controller's data drivers |
| dram_dq_in | input | DATA_W | Data from the DRAM |

## Verification
A negedge monitor records the cycle of every strobe edge. Timing is compared as exact counts: the column fall is due T_RCD+1 cycles after the row fall, and the column low width is due at exactly T_CAS. The row-high and column-high gaps and the row-active limit are checked as bounds. Each read seen at a column fall schedules a response due RD_LAT cycles later. At that monitor sample the bench expects `rsp_valid` together with the value from its own shadow memory, and a pulse in any other cycle is a failure. Row-reuse counts come from the number of row-strobe falls across a directed sequence. Host stimulus and refresh changes are driven shortly after the falling edge, and `req_ready` is read just before the rising edge, so acceptance is decided without any race.

// File: rtl/pgdram_pkg.sv
package pgdram_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ROWSET,
        ST_RCD,
        ST_COLSET,
        ST_CAS,
        ST_CP,
        ST_OPEN,
        ST_PRE,
        ST_REF
    } pg_state_e;

    function automatic int unsigned pg_max(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pgdram_rowtrk.sv
module pgdram_rowtrk #(
    parameter int unsigned ROW_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_i,
    input  logic             close_i,
    input  logic [ROW_W-1:0] row_i,
    output logic             hit_o
);
    logic             vld_d, vld_q;
    logic [ROW_W-1:0] row_d, row_q;

    always_comb begin
        vld_d = vld_q;
        row_d = row_q;
        if (close_i) begin
            vld_d = 1'b0;
        end
        if (open_i) begin
            vld_d = 1'b1;
            row_d = row_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            row_q <= '0;
        end else begin
            vld_q <= vld_d;
            row_q <= row_d;
        end
    end

    assign hit_o = vld_q && (row_q == row_i);
endmodule

// File: rtl/pgdram_agecnt.sv
module pgdram_agecnt #(
    parameter int unsigned T_RASMAX = 40,
    parameter int unsigned ACC_LEN  = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ras_low_i,
    output logic room_o
);
    localparam int unsigned AGE_W = $clog2(T_RASMAX + 2) + 1;
    localparam logic [AGE_W-1:0] AGE_SAT = AGE_W'(T_RASMAX + 1);

    logic [AGE_W-1:0] age_d, age_q;

    always_comb begin
        if (!ras_low_i) begin
            age_d = '0;
        end else if (age_q >= AGE_SAT) begin
            age_d = age_q;
        end else begin
            age_d = age_q + AGE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= '0;
        end else begin
            age_q <= age_d;
        end
    end

    // cycles already low (age_q), this cycle, and one more full access
    assign room_o = (32'(age_q) + 32'd1 + 32'(ACC_LEN)) <= 32'(T_RASMAX);
endmodule

// File: rtl/pgdram_rdcap.sv
module pgdram_rdcap #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_i,
    input  logic [DATA_W-1:0] dq_i,
    output logic              valid_o,
    output logic [DATA_W-1:0] data_o
);
    logic              vld_d, vld_q;
    logic [DATA_W-1:0] dat_d, dat_q;

    always_comb begin
        vld_d = sample_i;
        dat_d = sample_i ? dq_i : dat_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            dat_q <= '0;
        end else begin
            vld_q <= vld_d;
            dat_q <= dat_d;
        end
    end

    assign valid_o = vld_q;
    assign data_o  = dat_q;
endmodule

// File: rtl/pgdram_ctrl.sv
module pgdram_ctrl
    import pgdram_pkg::*;
#(
    parameter int unsigned ROW_W    = 10,
    parameter int unsigned COL_W    = 10,
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned T_RCD    = 2,
    parameter int unsigned T_CAS    = 3,
    parameter int unsigned T_CP     = 1,
    parameter int unsigned T_RP     = 2,
    parameter int unsigned T_RASMAX = 40,
    parameter int unsigned RD_LAT   = 2,
    localparam int unsigned ADDR_W  = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic              req_late,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic              ref_req,
    output logic              ref_gnt,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic              dram_we_n,
    output logic              dram_oe_n,
    output logic [ADDR_W-1:0] dram_addr,
    output logic [DATA_W-1:0] dram_dq_out,
    output logic              dram_dq_oe,
    input  logic [DATA_W-1:0] dram_dq_in
);
    localparam int unsigned CMAX    = pg_max(pg_max(T_RCD, T_CAS), pg_max(T_CP, T_RP));
    localparam int unsigned CNT_W   = $clog2(CMAX + 1) + 1;
    localparam int unsigned ACC_LEN = 2 + T_CAS + T_CP;

    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [COL_W-1:0]  col_t;
    typedef logic [DATA_W-1:0] data_t;

    typedef struct packed {
        pg_state_e st;
        cnt_t      cnt;
        logic      ras_n;
        logic      cas_n;
        logic      we_n;
        logic      oe_n;
        logic      dq_oe;
        addr_t     addr;
        logic      wr;
        logic      late;
        col_t      col;
        data_t     wdata;
    } ctl_t;

    localparam ctl_t CTL_RST = '{
        st: ST_IDLE, cnt: '0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1,
        oe_n: 1'b1, dq_oe: 1'b0, addr: '0, wr: 1'b0, late: 1'b0,
        col: '0, wdata: '0
    };

    ctl_t ctl_d, ctl_q;
    logic row_hit, age_room;
    logic open_row, close_row, sample_rd;

    // Set up the strobes for the cycle before the column strobe falls.
    function automatic ctl_t col_setup(ctl_t c, logic wr, logic late, col_t col, data_t wd);
        ctl_t r;
        r       = c;
        r.st    = ST_COLSET;
        r.addr  = addr_t'(col);
        r.col   = col;
        r.wr    = wr;
        r.late  = late;
        r.wdata = wd;
        r.we_n  = !(wr && !late);
        r.dq_oe = wr && !late;
        r.oe_n  = wr;
        return r;
    endfunction

    always_comb begin
        ctl_d     = ctl_q;
        req_ready = 1'b0;
        open_row  = 1'b0;
        close_row = 1'b0;
        sample_rd = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                ctl_d.ras_n = 1'b1;
                ctl_d.cas_n = 1'b1;
                ctl_d.we_n  = 1'b1;
                ctl_d.oe_n  = 1'b1;
                ctl_d.dq_oe = 1'b0;
                if (ref_req) begin
                    ctl_d.st = ST_REF;
                end else begin
                    req_ready = 1'b1;
                    if (req_valid) begin
                        open_row    = 1'b1;
                        ctl_d.st    = ST_ROWSET;
                        ctl_d.addr  = addr_t'(req_row);
                        ctl_d.col   = req_col;
                        ctl_d.wr    = req_we;
                        ctl_d.late  = req_late;
                        ctl_d.wdata = req_wdata;
                    end
                end
            end
            ST_ROWSET: begin
                ctl_d.ras_n = 1'b0;
                ctl_d.st    = ST_RCD;
                ctl_d.cnt   = cnt_t'(T_RCD - 1);
            end
            ST_RCD: begin
                if (ctl_q.cnt == '0) begin
                    ctl_d = col_setup(ctl_q, ctl_q.wr, ctl_q.late, ctl_q.col, ctl_q.wdata);
                end else begin
                    ctl_d.cnt = ctl_q.cnt - cnt_t'(1);
                end
            end
            ST_COLSET: begin
                ctl_d.cas_n = 1'b0;
                ctl_d.st    = ST_CAS;
                ctl_d.cnt   = '0;
            end
            ST_CAS: begin
                if (!ctl_q.wr && ctl_q.cnt == cnt_t'(RD_LAT - 1)) begin
                    sample_rd = 1'b1;
                end
                if (ctl_q.wr && ctl_q.late && ctl_q.cnt == '0) begin
                    ctl_d.we_n  = 1'b0;
                    ctl_d.dq_oe = 1'b1;
                end
                if (ctl_q.cnt == cnt_t'(T_CAS - 1)) begin
                    ctl_d.cas_n = 1'b1;
                    ctl_d.we_n  = 1'b1;
                    ctl_d.dq_oe = 1'b0;
                    ctl_d.oe_n  = 1'b1;
                    ctl_d.st    = (T_CP > 0) ? ST_CP : ST_OPEN;
                    ctl_d.cnt   = cnt_t'((T_CP > 0) ? (T_CP - 1) : 0);
                end else begin
                    ctl_d.cnt = ctl_q.cnt + cnt_t'(1);
                end
            end
            ST_CP: begin
                if (ctl_q.cnt == '0) begin
                    ctl_d.st = ST_OPEN;
                end else begin
                    ctl_d.cnt = ctl_q.cnt - cnt_t'(1);
                end
            end
            ST_OPEN: begin
                req_ready = !ref_req && row_hit && age_room;
                if (req_ready && req_valid) begin
                    ctl_d = col_setup(ctl_q, req_we, req_late, req_col, req_wdata);
                end else begin
                    close_row   = 1'b1;
                    ctl_d.ras_n = 1'b1;
                    ctl_d.st    = ST_PRE;
                    ctl_d.cnt   = cnt_t'(T_RP - 1);
                end
            end
            ST_PRE: begin
                if (ctl_q.cnt == '0) begin
                    ctl_d.st = ST_IDLE;
                end else begin
                    ctl_d.cnt = ctl_q.cnt - cnt_t'(1);
                end
            end
            ST_REF: begin
                if (!ref_req) begin
                    ctl_d.st = ST_IDLE;
                end
            end
            default: ctl_d = CTL_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= CTL_RST;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    pgdram_rowtrk #(.ROW_W(ROW_W)) u_rowtrk (
        .clk    (clk),
        .rst_n  (rst_n),
        .open_i (open_row),
        .close_i(close_row),
        .row_i  (req_row),
        .hit_o  (row_hit)
    );

    pgdram_agecnt #(.T_RASMAX(T_RASMAX), .ACC_LEN(ACC_LEN)) u_agecnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .ras_low_i(!ctl_q.ras_n),
        .room_o   (age_room)
    );

    pgdram_rdcap #(.DATA_W(DATA_W)) u_rdcap (
        .clk     (clk),
        .rst_n   (rst_n),
        .sample_i(sample_rd),
        .dq_i    (dram_dq_in),
        .valid_o (rsp_valid),
        .data_o  (rsp_rdata)
    );

    assign ref_gnt     = (ctl_q.st == ST_REF);
    assign dram_ras_n  = ctl_q.ras_n;
    assign dram_cas_n  = ctl_q.cas_n;
    assign dram_we_n   = ctl_q.we_n;
    assign dram_oe_n   = ctl_q.oe_n;
    assign dram_addr   = ctl_q.addr;
    assign dram_dq_out = ctl_q.wdata;
    assign dram_dq_oe  = ctl_q.dq_oe;
endmodule

// File: rtl/pgdram_chk.sv
module pgdram_chk #(
    parameter int unsigned ADDR_W   = 10,
    parameter int unsigned T_RP     = 2,
    parameter int unsigned T_RASMAX = 40
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic              oe_n,
    input logic              dq_oe,
    input logic [ADDR_W-1:0] addr,
    input logic              ref_req,
    input logic              ref_gnt,
    input logic              rsp_valid
);
    localparam int unsigned HW = $clog2(T_RP + 2) + 1;
    localparam int unsigned LW = $clog2(T_RASMAX + 2) + 1;

    logic [HW-1:0] hi_cnt;
    logic [LW-1:0] lo_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt <= HW'(T_RP);
            lo_cnt <= '0;
        end else begin
            if (!ras_n) begin
                hi_cnt <= '0;
            end else if (32'(hi_cnt) < T_RP + 1) begin
                hi_cnt <= hi_cnt + HW'(1);
            end
            if (ras_n) begin
                lo_cnt <= '0;
            end else if (32'(lo_cnt) < T_RASMAX + 1) begin
                lo_cnt <= lo_cnt + LW'(1);
            end
        end
    end

    p_cas_in_row_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !ras_n);
    p_row_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> $stable(addr));
    p_col_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> $stable(addr));
    p_rp_min_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (32'(hi_cnt) >= T_RP));
    p_ras_max_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> (32'(lo_cnt) < T_RASMAX));
    p_early_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cas_n) && !we_n) |-> dq_oe);
    p_drive_oe_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> oe_n);
    p_late_we_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(we_n) && $past(!cas_n)) |-> oe_n);
    p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    p_gnt_bus_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ref_gnt |-> (ras_n && cas_n));
    p_gnt_after_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_gnt) |-> $past(ref_req));
endmodule

bind pgdram_ctrl pgdram_chk #(
    .ADDR_W  (ADDR_W),
    .T_RP    (T_RP),
    .T_RASMAX(T_RASMAX)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ras_n    (dram_ras_n),
    .cas_n    (dram_cas_n),
    .we_n     (dram_we_n),
    .oe_n     (dram_oe_n),
    .dq_oe    (dram_dq_oe),
    .addr     (dram_addr),
    .ref_req  (ref_req),
    .ref_gnt  (ref_gnt),
    .rsp_valid(rsp_valid)
);

// File: tb/pgdram_ctrl_test.sv
module pgdram_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int ROW_W = 10, COL_W = 10, DATA_W = 16;
    localparam int T_RCD = 2, T_CAS = 3, T_CP = 1, T_RP = 2, T_RASMAX = 40, RD_LAT = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_we = 1'b0, req_late = 1'b0;
    logic [ROW_W-1:0] req_row = '0;
    logic [COL_W-1:0] req_col = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic ref_req = 1'b0;
    logic req_ready, rsp_valid, ref_gnt;
    logic [DATA_W-1:0] rsp_rdata;
    logic dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
    logic [9:0] dram_addr;
    logic [DATA_W-1:0] dram_dq_out, dram_dq_in;

    always #(CLK_PERIOD/2) clk = ~clk;

    pgdram_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .T_RCD(T_RCD),
        .T_CAS(T_CAS), .T_CP(T_CP), .T_RP(T_RP), .T_RASMAX(T_RASMAX), .RD_LAT(RD_LAT)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_we(req_we), .req_late(req_late), .req_row(req_row), .req_col(req_col),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .ref_req(ref_req), .ref_gnt(ref_gnt), .dram_ras_n(dram_ras_n),
        .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
        .dram_addr(dram_addr), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
        .dram_dq_in(dram_dq_in));

    int checks = 0, errors = 0;
    bit done = 0;

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // DRAM model and shadow memory: 8 rows x 16 columns
    logic [DATA_W-1:0] dmem [0:127];
    logic [DATA_W-1:0] smem [0:127];
    logic [2:0] lrow = '0;
    logic [3:0] lcol = '0;
    assign dram_dq_in = (!dram_ras_n && !dram_cas_n && dram_we_n && !dram_oe_n)
                        ? dmem[{lrow, lcol}] : '0;

    int ncnt = 0, ras_falls = 0, late_cnt = 0;
    int ras_fall_t = 0, ras_rise_t = 0, cas_fall_t = 0, cas_rise_t = 0;
    bit ras_rise_seen = 0, first_cas = 0;
    logic p_ras = 1, p_cas = 1, p_we = 1;
    int due[$];
    logic [DATA_W-1:0] expq[$];

    always @(negedge clk) begin
        if (rst_n) begin
            ncnt++;
            if (p_ras && !dram_ras_n) begin
                ras_falls++;
                if (ras_rise_seen)
                    chk(ncnt - ras_rise_t >= T_RP, "R5", "ras high gap", ncnt - ras_rise_t, T_RP);
                lrow = dram_addr[2:0];
                ras_fall_t = ncnt;
                first_cas = 1;
            end
            if (!p_ras && dram_ras_n) begin
                chk(ncnt - ras_fall_t <= T_RASMAX, "R11", "ras low width", ncnt - ras_fall_t, T_RASMAX);
                ras_rise_t = ncnt;
                ras_rise_seen = 1;
            end
            if (p_cas && !dram_cas_n) begin
                chk(!dram_ras_n, "R2", "cas falls inside row", dram_ras_n, 0);
                if (first_cas)
                    chk(ncnt - ras_fall_t == T_RCD + 1, "R6", "ras-to-cas", ncnt - ras_fall_t, T_RCD + 1);
                else
                    chk(ncnt - cas_rise_t >= T_CP, "R7", "cas high gap", ncnt - cas_rise_t, T_CP);
                first_cas = 0;
                lcol = dram_addr[3:0];
                cas_fall_t = ncnt;
                if (!dram_we_n) begin
                    chk(dram_dq_oe, "R8", "early write drivers on", dram_dq_oe, 1);
                    dmem[{lrow, dram_addr[3:0]}] = dram_dq_out;
                end else if (!dram_oe_n) begin
                    due.push_back(ncnt + RD_LAT);
                end
            end
            if (!p_cas && dram_cas_n) begin
                chk(ncnt - cas_fall_t == T_CAS, "R7", "cas low width", ncnt - cas_fall_t, T_CAS);
                cas_rise_t = ncnt;
            end
            if (p_we && !dram_we_n && !dram_cas_n && !p_cas) begin
                late_cnt++;
                chk(dram_oe_n && dram_dq_oe, "R9", "late write oe high and drivers on",
                    {dram_oe_n, dram_dq_oe}, 3);
                chk(ncnt - cas_fall_t == 1, "R9", "we falls one cycle after cas", ncnt - cas_fall_t, 1);
                if (dram_oe_n) dmem[{lrow, lcol}] = dram_dq_out;
            end
            if (ref_gnt)
                chk(dram_ras_n && dram_cas_n, "R12", "strobes high under grant", {dram_ras_n, dram_cas_n}, 3);
            if (due.size() > 0 && due[0] == ncnt) begin
                logic [DATA_W-1:0] e;
                void'(due.pop_front());
                e = (expq.size() > 0) ? expq.pop_front() : '0;
                chk(rsp_valid, "R10", "rsp_valid on due cycle", rsp_valid, 1);
                chk(rsp_rdata == e, "R10", "read data", rsp_rdata, e);
            end else if (rsp_valid) begin
                chk(0, "R10", "unexpected rsp_valid", 1, 0);
            end
            p_ras = dram_ras_n;
            p_cas = dram_cas_n;
            p_we  = dram_we_n;
        end
    end

    // Caller is at a negedge; returns at the negedge after acceptance.
    task automatic issue(bit we, bit late, int row, int col, logic [DATA_W-1:0] d);
        bit acc;
        req_valid = 1; req_we = we; req_late = late;
        req_row = ROW_W'(row); req_col = COL_W'(col); req_wdata = d;
        forever begin
            #3 acc = req_ready;
            @(posedge clk);
            if (acc) break;
            @(negedge clk);
        end
        if (we) smem[{row[2:0], col[3:0]}] = d;
        else expq.push_back(smem[{row[2:0], col[3:0]}]);
        @(negedge clk);
    endtask

    task automatic idle(int n);
        req_valid = 0;
        repeat (n) @(negedge clk);
    endtask

    task automatic ref_pulse(int hold);
        #1 ref_req = 1;
        @(negedge clk);
        while (!ref_gnt) @(negedge clk);
        repeat (hold) @(negedge clk);
        #1 ref_req = 0;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            chk(0, "R1", "watchdog expired", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int base;
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 128; i++) begin dmem[i] = '0; smem[i] = '0; end
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // reset state
        chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R1", "strobes high after reset",
            {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 15);
        chk(!dram_dq_oe && !rsp_valid && !ref_gnt, "R1", "drivers, rsp, grant low",
            {dram_dq_oe, rsp_valid, ref_gnt}, 0);
        chk(req_ready, "R1", "ready in idle", req_ready, 1);

        // early write then page-hit read
        issue(1, 0, 1, 2, 16'hA5A5);
        issue(0, 0, 1, 2, 0);
        idle(10);
        chk(ras_falls == 1, "R1", "first request opens a row", ras_falls, 1);
        chk(ras_falls == 1, "R3", "hit reuses row", ras_falls, 1);
        chk(dram_ras_n, "R13", "idle host closes row", dram_ras_n, 1);

        // late write then hit read
        base = ras_falls;
        issue(1, 1, 1, 3, 16'h3C3C);
        issue(0, 0, 1, 3, 0);
        idle(10);
        chk(late_cnt == 1, "R9", "one late write seen", late_cnt, 1);
        chk(ras_falls - base == 1, "R13", "row reopened after idle", ras_falls - base, 1);

        // page miss
        base = ras_falls;
        issue(0, 0, 1, 2, 0);
        issue(0, 0, 2, 2, 0);
        idle(10);
        chk(ras_falls - base == 2, "R4", "miss reopens row", ras_falls - base, 2);

        // row-active limit: 12 hits, two openings
        base = ras_falls;
        for (int k = 0; k < 12; k++) issue(k % 2, 0, 3, k, 16'(k * 7 + 1));
        idle(12);
        chk(ras_falls - base == 2, "R11", "forced close count", ras_falls - base, 2);

        // refresh with host idle
        base = ras_falls;
        ref_pulse(5);
        chk(ras_falls == base, "R12", "no row opened under grant", ras_falls - base, 0);
        idle(3);
        chk(!ref_gnt, "R12", "grant released", ref_gnt, 0);

        // refresh while a row is open
        base = ras_falls;
        issue(0, 0, 1, 2, 0);
        fork
            issue(0, 0, 1, 3, 0);
            ref_pulse(3);
        join
        idle(10);
        chk(ras_falls - base == 2, "R12", "refresh closes open row", ras_falls - base, 2);

        // random traffic
        for (int k = 0; k < 400; k++) begin
            int r = $urandom % 4, c = $urandom % 16, op = $urandom % 3;
            logic [DATA_W-1:0] d = 16'($urandom);
            if ($urandom % 12 == 0) begin
                fork
                    issue(op != 0, op == 2, r, c, d);
                    ref_pulse($urandom % 4);
                join
            end else begin
                issue(op != 0, op == 2, r, c, d);
            end
            if ($urandom % 6 == 0) idle(1 + $urandom % 4);
        end
        idle(20);
        chk(due.size() == 0, "R10", "no pending responses", due.size(), 0);
        chk(expq.size() == 0, "R10", "every read answered", expq.size(), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule